// File: doc/BRIEF.md
# Display Mode Register Window

This block is the software-visible control register file of a linear-framebuffer display controller. A bus master reaches it through a single address space split into two windows. The lower window holds a bank of 16-bit mode registers: resolution, colour depth, enable, virtual line width and panning offsets. Each register sits at an even byte address, and the register number is the byte address shifted right by one. The upper window is a small extension area of 32-bit registers. One of them reports the size of the window. Another selects the byte order of the framebuffer.

Two entries of the mode bank are not backed by storage when read. One returns a fixed identity code. The other reports the configured video memory in 64 KiB units. Register numbers past the end of the bank read as all ones in the 16-bit data lane, and writes to them are discarded. The byte-order flag changes only when one of two exact 32-bit patterns is written. Any other value leaves it alone. The current mode values and the byte-order flag are driven out as registered signals to the scan-out logic. Read data comes back one cycle after the request.

Top module: `disp_regwin`

## Requirements
- R1: While reset is high and on the first cycle after it, every mode output is zero, `fb_big_endian` is 0 and `rvalid` is 0.
- R2: A write to the lower window (`req_addr[8]`=0) with register number n = `req_addr[7:1]` below 11 stores `req_wdata[15:0]` in register n. The matching mode output shows it on the cycle after the write, and a later read of n returns it. The numbers are xres 1, yres 2, bpp 3, enable 4, virtual width 6, x offset 8 and y offset 9.
- R3: A read of register number 0 returns `ID_VALUE` (default 0xB0C5), whatever was written there.
- R4: A read of register number 10 returns `VMEM_BYTES / 65536`, which is 0x0100 at the default of 16 MiB.
- R5: A read of a register number of 11 or more returns 0x0000FFFF. A write to such a number changes no mode output and no stored register.
- R6: `rvalid` is high for exactly the one cycle after an accepted read, with `rdata` valid in that cycle. A write never raises `rvalid`.
- R7: In the upper window (`req_addr[8]`=1), byte offset 0 reads the window size, 0x00000100.
- R8: Upper-window byte offset 4 reads 0xBEBEBEBE while the framebuffer is big-endian and 0x1E1E1E1E while it is little-endian.
- R9: A write to upper offset 4 sets `fb_big_endian` only for the value 0xBEBEBEBE and clears it only for 0x1E1E1E1E. Any other value leaves the flag unchanged.
- R10: Every other upper-window byte offset, unaligned ones included, reads zero. Writes to those offsets change nothing.
- R11: Lower-window reads return zero in `rdata[31:16]`. Address bit 0 is ignored, and `req_wdata[31:16]` is ignored on lower-window writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | WIN_AW+1 (9) | Byte address; the top bit selects the upper window |
| req_wdata | input | 32 | Write data |
| rvalid | output | 1 | Read data valid (one cycle after a read) |
| rdata | output | 32 | Read data |
| mode_xres | output | 16 | Horizontal resolution register |
| mode_yres | output | 16 | Vertical resolution register |
| mode_bpp | output | 16 | Colour depth register |
| mode_enable | output | 16 | Enable register |
| mode_vwidth | output | 16 | Virtual line width register |
| mode_xoff | output | 16 | Horizontal panning offset |
| mode_yoff | output | 16 | Vertical panning offset |
| fb_big_endian | output | 1 | Framebuffer byte order, 1 = big-endian |

## Verification
The hardest case to reach from the ports is the byte-order flag ignoring near-miss values. The flag can only be seen to hold if it is first driven away from its reset value. The stimulus therefore sets big-endian with the exact pattern and then writes an arbitrary word and a one-bit-off pattern. After that it clears the flag, and it writes the big-endian pattern to unused and unaligned offsets next to the live register. After each step the flag port and a read of offset 4 are checked. The discarded out-of-range mode writes are covered by a sweep over all 128 register numbers. After every write the sweep compares all seven mode outputs against a model, and it then reads back every number.

// File: rtl/dregs_pkg.sv
package dregs_pkg;
  localparam int IDX_ID     = 0;
  localparam int IDX_XRES   = 1;
  localparam int IDX_YRES   = 2;
  localparam int IDX_BPP    = 3;
  localparam int IDX_ENABLE = 4;
  localparam int IDX_VWIDTH = 6;
  localparam int IDX_XOFF   = 8;
  localparam int IDX_YOFF   = 9;
  localparam int IDX_VMEM   = 10;
  localparam int NUM_MODE_REGS = 11;

  localparam int EXT_OFS_SIZE  = 0;
  localparam int EXT_OFS_ORDER = 4;

  localparam logic [31:0] ORDER_LITTLE = 32'h1E1E_1E1E;
  localparam logic [31:0] ORDER_BIG    = 32'hBEBE_BEBE;

  typedef struct packed {
    logic [15:0] xres;
    logic [15:0] yres;
    logic [15:0] bpp;
    logic [15:0] enable;
    logic [15:0] vwidth;
    logic [15:0] xoff;
    logic [15:0] yoff;
  } mode_view_t;
endpackage

// File: rtl/dregs_mode_bank.sv
module dregs_mode_bank
  import dregs_pkg::*;
#(
  parameter int NREG  = NUM_MODE_REGS,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [15:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [15:0]      rd_data,
  output mode_view_t       view
);
  logic [NREG-1:0][15:0] bank;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [15:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        q <= wr_data;
      end
    end
    assign bank[g] = q;
  end

  always_comb begin
    rd_data = '1;
    for (int k = 0; k < NREG; k++) begin
      if (rd_idx == IDX_W'(k)) rd_data = bank[k];
    end
  end

  assign view.xres   = bank[IDX_XRES];
  assign view.yres   = bank[IDX_YRES];
  assign view.bpp    = bank[IDX_BPP];
  assign view.enable = bank[IDX_ENABLE];
  assign view.vwidth = bank[IDX_VWIDTH];
  assign view.xoff   = bank[IDX_XOFF];
  assign view.yoff   = bank[IDX_YOFF];
endmodule

// File: rtl/dregs_ext_window.sv
module dregs_ext_window
  import dregs_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [31:0]      wr_data,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic [31:0]      rd_data,
  output logic             big_endian
);
  localparam logic [31:0] WIN_SIZE = 32'(2 ** OFS_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      big_endian <= 1'b0;
    end else if (wr_en && (wr_ofs == OFS_W'(EXT_OFS_ORDER))) begin
      if (wr_data == ORDER_BIG)         big_endian <= 1'b1;
      else if (wr_data == ORDER_LITTLE) big_endian <= 1'b0;
    end
  end

  always_comb begin
    if (rd_ofs == OFS_W'(EXT_OFS_SIZE))       rd_data = WIN_SIZE;
    else if (rd_ofs == OFS_W'(EXT_OFS_ORDER)) rd_data = big_endian ? ORDER_BIG : ORDER_LITTLE;
    else                                      rd_data = '0;
  end
endmodule

// File: rtl/dregs_read_mux.sv
module dregs_read_mux
  import dregs_pkg::*;
#(
  parameter int          IDX_W      = 7,
  parameter logic [15:0] ID_VALUE   = 16'hB0C5,
  parameter logic [15:0] VMEM_UNITS = 16'h0100
) (
  input  logic             sel_ext,
  input  logic [IDX_W-1:0] idx,
  input  logic [15:0]      bank_data,
  input  logic [31:0]      ext_data,
  output logic [31:0]      word
);
  always_comb begin
    if (sel_ext)                        word = ext_data;
    else if (idx == IDX_W'(IDX_ID))     word = {16'h0000, ID_VALUE};
    else if (idx == IDX_W'(IDX_VMEM))   word = {16'h0000, VMEM_UNITS};
    else                                word = {16'h0000, bank_data};
  end
endmodule

// File: rtl/disp_regwin.sv
module disp_regwin
  import dregs_pkg::*;
#(
  parameter int          WIN_AW     = 8,
  parameter int unsigned VMEM_BYTES = 16 * 1024 * 1024,
  parameter logic [15:0] ID_VALUE   = 16'hB0C5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [WIN_AW:0] req_addr,
  input  logic [31:0]     req_wdata,
  output logic            rvalid,
  output logic [31:0]     rdata,
  output logic [15:0]     mode_xres,
  output logic [15:0]     mode_yres,
  output logic [15:0]     mode_bpp,
  output logic [15:0]     mode_enable,
  output logic [15:0]     mode_vwidth,
  output logic [15:0]     mode_xoff,
  output logic [15:0]     mode_yoff,
  output logic            fb_big_endian
);
  localparam int          IDX_W      = WIN_AW - 1;
  localparam logic [15:0] VMEM_UNITS = 16'(VMEM_BYTES / 65536);

  logic              sel_ext;
  logic [IDX_W-1:0]  mode_idx;
  logic [WIN_AW-1:0] ext_ofs;
  logic [15:0]       bank_rd;
  logic [31:0]       ext_rd;
  logic [31:0]       rd_word;
  mode_view_t        view;

  assign sel_ext  = req_addr[WIN_AW];
  assign mode_idx = req_addr[WIN_AW-1:1];
  assign ext_ofs  = req_addr[WIN_AW-1:0];

  dregs_mode_bank #(.NREG(NUM_MODE_REGS), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (req_valid && req_write && !sel_ext),
    .wr_idx  (mode_idx),
    .wr_data (req_wdata[15:0]),
    .rd_idx  (mode_idx),
    .rd_data (bank_rd),
    .view    (view)
  );

  dregs_ext_window #(.OFS_W(WIN_AW)) u_ext (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (req_valid && req_write && sel_ext),
    .wr_ofs     (ext_ofs),
    .wr_data    (req_wdata),
    .rd_ofs     (ext_ofs),
    .rd_data    (ext_rd),
    .big_endian (fb_big_endian)
  );

  dregs_read_mux #(.IDX_W(IDX_W), .ID_VALUE(ID_VALUE), .VMEM_UNITS(VMEM_UNITS)) u_mux (
    .sel_ext   (sel_ext),
    .idx       (mode_idx),
    .bank_data (bank_rd),
    .ext_data  (ext_rd),
    .word      (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= req_valid && !req_write;
      if (req_valid && !req_write) rdata <= rd_word;
    end
  end

  assign mode_xres   = view.xres;
  assign mode_yres   = view.yres;
  assign mode_bpp    = view.bpp;
  assign mode_enable = view.enable;
  assign mode_vwidth = view.vwidth;
  assign mode_xoff   = view.xoff;
  assign mode_yoff   = view.yoff;
endmodule

// File: rtl/disp_regwin_chk.sv
module disp_regwin_chk
  import dregs_pkg::*;
#(
  parameter int          WIN_AW     = 8,
  parameter int unsigned VMEM_BYTES = 16 * 1024 * 1024,
  parameter logic [15:0] ID_VALUE   = 16'hB0C5
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_write,
  input logic [WIN_AW:0] req_addr,
  input logic [31:0]     req_wdata,
  input logic            rvalid,
  input logic [31:0]     rdata,
  input logic [15:0]     mode_xres,
  input logic [15:0]     mode_yres,
  input logic [15:0]     mode_bpp,
  input logic [15:0]     mode_enable,
  input logic [15:0]     mode_vwidth,
  input logic [15:0]     mode_xoff,
  input logic [15:0]     mode_yoff,
  input logic            fb_big_endian
);
  localparam int IDX_W = WIN_AW - 1;

  logic [WIN_AW:0]   order_addr;
  logic [IDX_W-1:0]  idx;
  logic              rd_req, wr_req, mode_oob_wr;
  logic [111:0]      all_modes;

  assign order_addr  = {1'b1, WIN_AW'(EXT_OFS_ORDER)};
  assign idx         = req_addr[WIN_AW-1:1];
  assign rd_req      = req_valid && !req_write;
  assign wr_req      = req_valid && req_write;
  assign mode_oob_wr = wr_req && !req_addr[WIN_AW] && (idx >= IDX_W'(NUM_MODE_REGS));
  assign all_modes   = {mode_xres, mode_yres, mode_bpp, mode_enable, mode_vwidth, mode_xoff, mode_yoff};

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (all_modes == '0 && !fb_big_endian && !rvalid));

  assert_read_resp_R6: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rvalid);

  assert_no_spurious_resp_R6: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(rd_req));

  assert_id_const_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !req_addr[WIN_AW] && idx == IDX_W'(IDX_ID)) |=> rdata == {16'h0, ID_VALUE});

  assert_vmem_const_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !req_addr[WIN_AW] && idx == IDX_W'(IDX_VMEM)) |=> rdata == {16'h0, 16'(VMEM_BYTES / 65536)});

  assert_oob_write_dropped_R5: assert property (@(posedge clk) disable iff (rst)
    mode_oob_wr |=> $stable(all_modes));

  assert_order_only_via_reg_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(fb_big_endian) |-> $past(wr_req && req_addr == order_addr));

  assert_order_set_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_req && req_addr == order_addr && req_wdata == ORDER_BIG) |=> fb_big_endian);

  assert_order_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_req && req_addr == order_addr && req_wdata == ORDER_LITTLE) |=> !fb_big_endian);

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !req_addr[WIN_AW]) |=> rdata[31:16] == 16'h0);
endmodule

bind disp_regwin disp_regwin_chk #(.WIN_AW(WIN_AW), .VMEM_BYTES(VMEM_BYTES), .ID_VALUE(ID_VALUE)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
  .req_wdata(req_wdata), .rvalid(rvalid), .rdata(rdata), .mode_xres(mode_xres),
  .mode_yres(mode_yres), .mode_bpp(mode_bpp), .mode_enable(mode_enable),
  .mode_vwidth(mode_vwidth), .mode_xoff(mode_xoff), .mode_yoff(mode_yoff),
  .fb_big_endian(fb_big_endian)
);

// File: tb/tb_disp_regwin.sv
module tb_disp_regwin;
  localparam int WIN_AW = 8;
  localparam int NREG   = 11;
  localparam logic [15:0] ID_EXP   = 16'hB0C5;
  localparam logic [15:0] VMEM_EXP = 16'h0100;
  localparam logic [31:0] BIG = 32'hBEBE_BEBE;
  localparam logic [31:0] LIT = 32'h1E1E_1E1E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [WIN_AW:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rvalid;
  logic [31:0] rdata;
  logic [15:0] mode_xres, mode_yres, mode_bpp, mode_enable, mode_vwidth, mode_xoff, mode_yoff;
  logic fb_big_endian;

  int n_checks = 0;
  int n_fail = 0;
  logic [15:0] model [NREG];
  logic model_be = 1'b0;

  always #2 clk = ~clk;

  disp_regwin dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rvalid(rvalid), .rdata(rdata), .mode_xres(mode_xres),
    .mode_yres(mode_yres), .mode_bpp(mode_bpp), .mode_enable(mode_enable),
    .mode_vwidth(mode_vwidth), .mode_xoff(mode_xoff), .mode_yoff(mode_yoff),
    .fb_big_endian(fb_big_endian)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  task automatic wr(input logic [WIN_AW:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R6", "rvalid after write", {31'b0, rvalid}, 32'd0);
  endtask

  task automatic rd(input logic [WIN_AW:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R6", "rvalid after read", {31'b0, rvalid}, 32'd1);
    d = rdata;
    @(negedge clk);
    check("R6", "rvalid one cycle only", {31'b0, rvalid}, 32'd0);
  endtask

  task automatic check_modes(input string req);
    check(req, "xres",   {16'h0, mode_xres},   {16'h0, model[1]});
    check(req, "yres",   {16'h0, mode_yres},   {16'h0, model[2]});
    check(req, "bpp",    {16'h0, mode_bpp},    {16'h0, model[3]});
    check(req, "enable", {16'h0, mode_enable}, {16'h0, model[4]});
    check(req, "vwidth", {16'h0, mode_vwidth}, {16'h0, model[6]});
    check(req, "xoff",   {16'h0, mode_xoff},   {16'h0, model[8]});
    check(req, "yoff",   {16'h0, mode_yoff},   {16'h0, model[9]});
  endtask

  task automatic check_order(input string req);
    logic [31:0] d;
    check(req, "fb_big_endian", {31'b0, fb_big_endian}, {31'b0, model_be});
    rd({1'b1, 8'd4}, d);
    check("R8", "order readback", d, model_be ? BIG : LIT);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R6 watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < NREG; i++) model[i] = 16'h0;
    repeat (3) @(negedge clk);
    // R1: during reset
    check_modes("R1");
    check("R1", "be in reset", {31'b0, fb_big_endian}, 32'd0);
    check("R1", "rvalid in reset", {31'b0, rvalid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check_modes("R1");
    check("R1", "rvalid after reset", {31'b0, rvalid}, 32'd0);

    // R2, R5, R11: write every register number, odd numbers via odd byte address
    for (int i = 0; i < 128; i++) begin
      logic [15:0] v;
      v = 16'(i * 16'h1357) ^ 16'hA5C3;
      wr({1'b0, 7'(i), 1'(i & 1)}, {16'hDEAD, v});
      if (i < NREG) model[i] = v;
      check_modes(i < NREG ? "R2" : "R5");
    end

    // R2, R3, R4, R5, R11: read every register number
    for (int i = 0; i < 128; i++) begin
      logic [31:0] e;
      rd({1'b0, 7'(i), 1'b0}, d);
      if (i == 0)        begin e = {16'h0, ID_EXP};   check("R3", "id read", d, e); end
      else if (i == 10)  begin e = {16'h0, VMEM_EXP}; check("R4", "vmem read", d, e); end
      else if (i < NREG) begin e = {16'h0, model[i]}; check("R2", "bank read", d, e); end
      else               begin e = 32'h0000_FFFF;     check("R5", "oob read", d, e); end
      check("R11", "upper half zero", {16'h0, d[31:16]}, 32'h0);
    end

    // R7, R8, R10: sweep every upper-window byte offset
    for (int o = 0; o < 256; o++) begin
      rd({1'b1, 8'(o)}, d);
      if (o == 0)      check("R7", "size read", d, 32'h0000_0100);
      else if (o == 4) check("R8", "order read LE", d, LIT);
      else             check("R10", "unused read", d, 32'h0);
    end

    // R9: byte order sequence
    wr({1'b1, 8'd4}, BIG);        model_be = 1'b1; check_order("R9");
    wr({1'b1, 8'd4}, 32'h1234_5678);               check_order("R9");
    wr({1'b1, 8'd4}, LIT ^ 32'h1);                 check_order("R9");
    wr({1'b1, 8'd4}, LIT);        model_be = 1'b0; check_order("R9");
    wr({1'b1, 8'd4}, BIG ^ 32'h8000_0000);         check_order("R9");
    // R10: magic at unused or unaligned offsets has no effect
    wr({1'b1, 8'd8}, BIG);                         check_order("R10");
    wr({1'b1, 8'd5}, BIG);                         check_order("R10");
    wr({1'b1, 8'd0}, BIG);                         check_order("R10");
    rd({1'b1, 8'd0}, d);
    check("R10", "size after write", d, 32'h0000_0100);
    rd({1'b1, 8'd8}, d);
    check("R10", "unused after write", d, 32'h0);
    check_modes("R10");

    summary();
  end
endmodule